// File: doc/BRIEF.md
# Nested Hardware Loop Context Stack

This block keeps the context of nested zero-overhead loops for a sequencer. It has three columns: iteration count, loop start address and loop end address. Each column is a four-level shift-register stack. Level 0 holds the innermost, currently active loop. Software or decode logic can push onto and pop from each column on its own. It can overwrite the level-0 count directly and write any single entry by column and level. A flat twelve-entry read window shows every stored value.

Each cycle the block compares the fetch PC with the level-0 end address. If the innermost loop still has iterations left, it asserts a redirect to the level-0 start address and counts the iteration off. On the last iteration it drops the whole loop context: all three columns pop together. A nonzero value in the deepest level means that column is full. A push into a full column is refused and raises a sticky overflow flag. Malformed indices raise a separate sticky index flag.

Top module: `loop_ctx_stack`

## Requirements
- R1: Reset clears every entry of every column, both error flags, and the redirect output.
- R2: A push moves every entry of the pushed column one level deeper and writes the pushed value into level 0.
- R3: A pop moves every entry of the popped column one level toward level 0 and writes zero into the deepest level.
- R4: A push into a column whose deepest entry is nonzero leaves that column unchanged and sets `err_ovf` from the next cycle.
- R5: The columns are independent. Bit 0 of `push_en`/`pop_en` selects the count column, bit 1 the start column and bit 2 the end column.
- R6: The window shows the counts of levels 0–3 at `win_idx` 0–3, the start addresses at 4–7 and the end addresses at 8–11. For indices 12–15, `win_data` is zero, and a `win_rd` strobe sets `err_idx`.
- R7: `l0_cnt`, `l0_start` and `l0_end` always show level 0. `l0w_en` overwrites the level-0 count with `l0w_val`.
- R8: `wr_en` writes `wr_val` into column `wr_col` (0 count, 1 start, 2 end) at level `wr_lvl`. If `wr_col` is 3 or `wr_lvl` is 4 or more, nothing changes and `err_idx` is set.
- R9: When `pc_vld` is high, the level-0 count is above one and `pc` equals the level-0 end address, `redirect` is high in that cycle with `redirect_pc` equal to the level-0 start address, and the level-0 count drops by one in the next cycle. A level-0 count of zero never matches.
- R10: When the same match happens with a level-0 count of exactly one, `redirect` stays low and all three columns pop in that cycle.
- R11: Each column performs one operation per cycle. The order of precedence is: loop-end action, then push (including a refused push), then pop, then level-0 count write, then indexed write.
- R12: Both error flags stay set until `err_clr`. A new error in the same cycle as `err_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 3 | Per-column push request (bit 0 count, bit 1 start, bit 2 end) |
| pop_en | input | 3 | Per-column pop request, same bit order |
| push_cnt | input | 32 | Value pushed onto the count column |
| push_start | input | 32 | Value pushed onto the start column |
| push_end | input | 32 | Value pushed onto the end column |
| l0w_en | input | 1 | Overwrite the level-0 count |
| l0w_val | input | 32 | Value for the level-0 count overwrite |
| wr_en | input | 1 | Indexed single-entry write |
| wr_col | input | 2 | Column for the indexed write |
| wr_lvl | input | 3 | Level for the indexed write |
| wr_val | input | 32 | Data for the indexed write |
| win_rd | input | 1 | Window read strobe (qualifies the index check) |
| win_idx | input | 4 | Window index |
| win_data | output | 32 | Window read data |
| l0_cnt | output | 32 | Level-0 iteration count |
| l0_start | output | 32 | Level-0 start address |
| l0_end | output | 32 | Level-0 end address |
| pc_vld | input | 1 | `pc` is valid this cycle |
| pc | input | 32 | Current fetch address |
| redirect | output | 1 | Branch back to the loop start |
| redirect_pc | output | 32 | Redirect target |
| err_clr | input | 1 | Clear both error flags |
| err_ovf | output | 1 | Sticky overflow flag |
| err_idx | output | 1 | Sticky invalid-index flag |

## Verification
The hardest cases to reach are the ones where the loop-end match competes with commands in the same cycle: a final-iteration exit popping all columns while a push or indexed write targets the same column, or an overflow refused while a clear is requested. The stimulus builds these cases deliberately. It first fills a column to four nonzero levels, then pushes into it again. It then sets up a short loop and drives the PC onto the recorded end address while loading conflicting commands. A long random phase follows, which aims the PC at the model's current end address half of the time and keeps counts small so loops end often.

// File: rtl/lstk_pkg.sv
package lstk_pkg;

   // column order is visible in the window map and the push/pop bit order
   localparam int NCOL      = 3;
   localparam int COL_CNT   = 0;
   localparam int COL_START = 1;
   localparam int COL_END   = 2;

   typedef enum logic [2:0] {
      OP_HOLD = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_DEC  = 3'd3,
      OP_SET  = 3'd4
   } col_op_e;

endpackage

// File: rtl/lstk_column.sv
module lstk_column
   import lstk_pkg::*;
#(
   parameter  int DW    = 32,
   parameter  int DEPTH = 4,
   localparam int LVW   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  col_op_e             op,
   input  logic [DW-1:0]       wdata,
   input  logic [LVW-1:0]      widx,
   output logic [DEPTH*DW-1:0] flat,
   output logic                full
);

   logic [DW-1:0] ent [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else begin
         case (op)
            OP_PUSH: begin
               ent[0] <= wdata;
               for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
            end
            OP_POP: begin
               for (int i = 0; i < DEPTH-1; i++) ent[i] <= ent[i+1];
               ent[DEPTH-1] <= '0;
            end
            OP_DEC:  ent[0]    <= ent[0] - DW'(1);
            OP_SET:  ent[widx] <= wdata;
            default: ;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_flat
         assign flat[g*DW +: DW] = ent[g];
      end
   endgenerate

   // deepest slot nonzero marks the column as having no free level
   assign full = (ent[DEPTH-1] != '0);

endmodule

// File: rtl/lstk_window.sv
module lstk_window
   import lstk_pkg::*;
#(
   parameter  int DW    = 32,
   parameter  int DEPTH = 4,
   parameter  int WIN_W = 4,
   localparam int NWIN  = NCOL*DEPTH
) (
   input  logic [WIN_W-1:0]                idx,
   input  logic [NCOL-1:0][DEPTH*DW-1:0]   col_flat,
   output logic [DW-1:0]                   data,
   output logic                            bad
);

   logic [NWIN-1:0][DW-1:0] slot;

   generate
      for (genvar c = 0; c < NCOL; c++) begin : g_col
         for (genvar l = 0; l < DEPTH; l++) begin : g_lvl
            assign slot[c*DEPTH + l] = col_flat[c][l*DW +: DW];
         end
      end
   endgenerate

   assign bad = (int'(idx) >= NWIN);

   always_comb begin
      data = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (idx == WIN_W'(i)) data = slot[i];
      end
   end

endmodule

// File: rtl/lstk_ctrl.sv
module lstk_ctrl
   import lstk_pkg::*;
#(
   parameter  int DW    = 32,
   parameter  int DEPTH = 4,
   localparam int LVW   = $clog2(DEPTH)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DW-1:0]               l0_cnt,
   input  logic [DW-1:0]               l0_start,
   input  logic [DW-1:0]               l0_end,
   input  logic [NCOL-1:0]             full,
   input  logic [NCOL-1:0]             push_en,
   input  logic [NCOL-1:0]             pop_en,
   input  logic [NCOL-1:0][DW-1:0]     push_val,
   input  logic                        l0w_en,
   input  logic [DW-1:0]               l0w_val,
   input  logic                        wr_en,
   input  logic [1:0]                  wr_col,
   input  logic [LVW:0]                wr_lvl,
   input  logic [DW-1:0]               wr_val,
   input  logic                        win_rd,
   input  logic                        win_bad,
   input  logic                        pc_vld,
   input  logic [DW-1:0]               pc,
   input  logic                        err_clr,
   output col_op_e                     op    [NCOL],
   output logic [NCOL-1:0][DW-1:0]     wdata,
   output logic [NCOL-1:0][LVW-1:0]    widx,
   output logic                        redirect,
   output logic [DW-1:0]               redirect_pc,
   output logic                        err_ovf,
   output logic                        err_idx
);

   logic            hit, do_loop, do_exit, wr_ok;
   logic [NCOL-1:0] ovf_hit;
   logic            idx_set;

   assign hit     = pc_vld && (l0_cnt != '0) && (pc == l0_end);
   assign do_loop = hit && (l0_cnt > DW'(1));
   assign do_exit = hit && (l0_cnt == DW'(1));
   assign wr_ok   = (int'(wr_col) < NCOL) && (int'(wr_lvl) < DEPTH);

   // one operation per column, fixed precedence
   always_comb begin
      for (int c = 0; c < NCOL; c++) begin
         op[c]      = OP_HOLD;
         wdata[c]   = push_val[c];
         widx[c]    = '0;
         ovf_hit[c] = 1'b0;
         if (do_exit) begin
            op[c] = OP_POP;
         end else if (c == COL_CNT && do_loop) begin
            op[c] = OP_DEC;
         end else if (push_en[c]) begin
            if (full[c]) ovf_hit[c] = 1'b1;
            else         op[c]      = OP_PUSH;
         end else if (pop_en[c]) begin
            op[c] = OP_POP;
         end else if (c == COL_CNT && l0w_en) begin
            op[c]    = OP_SET;
            wdata[c] = l0w_val;
         end else if (wr_en && wr_ok && (wr_col == 2'(c))) begin
            op[c]    = OP_SET;
            wdata[c] = wr_val;
            widx[c]  = wr_lvl[LVW-1:0];
         end
      end
   end

   assign idx_set = (wr_en && !wr_ok) || (win_rd && win_bad);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_ovf <= 1'b0;
         err_idx <= 1'b0;
      end else begin
         err_ovf <= (err_ovf && !err_clr) || (|ovf_hit);
         err_idx <= (err_idx && !err_clr) || idx_set;
      end
   end

   assign redirect    = do_loop;
   assign redirect_pc = l0_start;

endmodule

// File: rtl/loop_ctx_stack.sv
module loop_ctx_stack
   import lstk_pkg::*;
#(
   parameter  int DW    = 32,
   parameter  int DEPTH = 4,
   parameter  int WIN_W = 4,
   localparam int LVW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCOL-1:0]   push_en,
   input  logic [NCOL-1:0]   pop_en,
   input  logic [DW-1:0]     push_cnt,
   input  logic [DW-1:0]     push_start,
   input  logic [DW-1:0]     push_end,
   input  logic              l0w_en,
   input  logic [DW-1:0]     l0w_val,
   input  logic              wr_en,
   input  logic [1:0]        wr_col,
   input  logic [LVW:0]      wr_lvl,
   input  logic [DW-1:0]     wr_val,
   input  logic              win_rd,
   input  logic [WIN_W-1:0]  win_idx,
   output logic [DW-1:0]     win_data,
   output logic [DW-1:0]     l0_cnt,
   output logic [DW-1:0]     l0_start,
   output logic [DW-1:0]     l0_end,
   input  logic              pc_vld,
   input  logic [DW-1:0]     pc,
   output logic              redirect,
   output logic [DW-1:0]     redirect_pc,
   input  logic              err_clr,
   output logic              err_ovf,
   output logic              err_idx
);

   generate
      if (DEPTH < 2 || (1 << LVW) != DEPTH) begin : g_bad_depth
         $error("loop_ctx_stack: DEPTH must be a power of two, at least 2");
      end
      if ((1 << WIN_W) < NCOL*DEPTH) begin : g_bad_win
         $error("loop_ctx_stack: WIN_W too narrow for the window");
      end
      if (DW < 2) begin : g_bad_dw
         $error("loop_ctx_stack: DW too small");
      end
   endgenerate

   logic [NCOL-1:0][DEPTH*DW-1:0] col_flat;
   logic [NCOL-1:0]               full;
   logic [NCOL-1:0][DW-1:0]       push_val;
   col_op_e                       op    [NCOL];
   logic [NCOL-1:0][DW-1:0]       wdata;
   logic [NCOL-1:0][LVW-1:0]      widx;
   logic                          win_bad;

   assign push_val[COL_CNT]   = push_cnt;
   assign push_val[COL_START] = push_start;
   assign push_val[COL_END]   = push_end;

   generate
      for (genvar c = 0; c < NCOL; c++) begin : g_col
         lstk_column #(.DW(DW), .DEPTH(DEPTH)) u_col (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (op[c]),
            .wdata (wdata[c]),
            .widx  (widx[c]),
            .flat  (col_flat[c]),
            .full  (full[c])
         );
      end
   endgenerate

   assign l0_cnt   = col_flat[COL_CNT][DW-1:0];
   assign l0_start = col_flat[COL_START][DW-1:0];
   assign l0_end   = col_flat[COL_END][DW-1:0];

   lstk_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .l0_cnt      (l0_cnt),
      .l0_start    (l0_start),
      .l0_end      (l0_end),
      .full        (full),
      .push_en     (push_en),
      .pop_en      (pop_en),
      .push_val    (push_val),
      .l0w_en      (l0w_en),
      .l0w_val     (l0w_val),
      .wr_en       (wr_en),
      .wr_col      (wr_col),
      .wr_lvl      (wr_lvl),
      .wr_val      (wr_val),
      .win_rd      (win_rd),
      .win_bad     (win_bad),
      .pc_vld      (pc_vld),
      .pc          (pc),
      .err_clr     (err_clr),
      .op          (op),
      .wdata       (wdata),
      .widx        (widx),
      .redirect    (redirect),
      .redirect_pc (redirect_pc),
      .err_ovf     (err_ovf),
      .err_idx     (err_idx)
   );

   lstk_window #(.DW(DW), .DEPTH(DEPTH), .WIN_W(WIN_W)) u_win (
      .idx      (win_idx),
      .col_flat (col_flat),
      .data     (win_data),
      .bad      (win_bad)
   );

endmodule

// File: rtl/lstk_chk.sv
module lstk_chk
   import lstk_pkg::*;
#(
   parameter  int DW    = 32,
   parameter  int DEPTH = 4,
   parameter  int WIN_W = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NCOL-1:0]               push_en,
   input logic [NCOL-1:0]               pop_en,
   input logic [DW-1:0]                 push_start,
   input logic                          pc_vld,
   input logic [DW-1:0]                 pc,
   input logic                          win_rd,
   input logic [WIN_W-1:0]              win_idx,
   input logic                          err_clr,
   input logic                          redirect,
   input logic [DW-1:0]                 l0_cnt,
   input logic [DW-1:0]                 l0_start,
   input logic [DW-1:0]                 l0_end,
   input logic                          err_ovf,
   input logic                          err_idx,
   input logic [NCOL-1:0][DEPTH*DW-1:0] col_flat
);

   logic          last_iter;
   logic [DW-1:0] start_deep, end_lvl1;

   assign last_iter  = pc_vld && (l0_cnt == DW'(1)) && (pc == l0_end);
   assign start_deep = col_flat[COL_START][(DEPTH-1)*DW +: DW];
   assign end_lvl1   = col_flat[COL_END][DW +: DW];

   a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |=> (l0_cnt == $past(l0_cnt) - DW'(1)));

   a_r10_no_redirect_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
      last_iter |-> !redirect);

   a_r10_exit_pops_end: assert property (@(posedge clk) disable iff (!rst_n)
      last_iter |=> (l0_end == $past(end_lvl1)));

   a_r4_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en[COL_START] && start_deep != '0 && !last_iter) |=> err_ovf);

   a_r2_push_lands_l0: assert property (@(posedge clk) disable iff (!rst_n)
      (push_en[COL_START] && start_deep == '0 && !last_iter) |=> (l0_start == $past(push_start)));

   a_r3_pop_clears_deep: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_en[COL_START] && !push_en[COL_START]) |=> (start_deep == '0));

   a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ovf && !err_clr) |=> err_ovf);

   a_r6_bad_window: assert property (@(posedge clk) disable iff (!rst_n)
      (win_rd && int'(win_idx) >= NCOL*DEPTH) |=> err_idx);

endmodule

bind loop_ctx_stack lstk_chk #(.DW(DW), .DEPTH(DEPTH), .WIN_W(WIN_W)) u_chk (.*);

// File: tb/sim_loop_ctx_stack.sv
module sim_loop_ctx_stack;

   localparam int DW = 32, DEPTH = 4, WIN_W = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n;
   logic [2:0]  push_en, pop_en;
   logic [31:0] push_cnt, push_start, push_end;
   logic        l0w_en;   logic [31:0] l0w_val;
   logic        wr_en;    logic [1:0]  wr_col;  logic [2:0] wr_lvl; logic [31:0] wr_val;
   logic        win_rd;   logic [3:0]  win_idx;
   logic [31:0] win_data, l0_cnt, l0_start, l0_end;
   logic        pc_vld;   logic [31:0] pc;
   logic        redirect; logic [31:0] redirect_pc;
   logic        err_clr, err_ovf, err_idx;

   loop_ctx_stack #(.DW(DW), .DEPTH(DEPTH), .WIN_W(WIN_W)) u0 (.*);

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // behavioural reference: m[column][level]
   logic [31:0] m [3][4];
   bit mo, mi;

   task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
      end
   endtask

   task automatic idle();
      push_en = 0; pop_en = 0; push_cnt = 0; push_start = 0; push_end = 0;
      l0w_en = 0; l0w_val = 0; wr_en = 0; wr_col = 0; wr_lvl = 0; wr_val = 0;
      win_rd = 0; win_idx = 0; pc_vld = 0; pc = 0; err_clr = 0;
   endtask

   task automatic compare(string tag);
      logic hit, loop_more;
      logic [31:0] wexp;
      hit       = pc_vld && m[0][0] != 0 && pc == m[2][0];
      loop_more = hit && m[0][0] > 1;
      wexp      = (win_idx < 12) ? m[win_idx/4][win_idx%4] : 32'd0;
      chk(tag, "l0_cnt", l0_cnt, m[0][0]);
      chk(tag, "l0_start", l0_start, m[1][0]);
      chk(tag, "l0_end", l0_end, m[2][0]);
      chk(tag, "win_data", win_data, wexp);
      chk(tag, "redirect", {31'd0, redirect}, {31'd0, loop_more});
      if (loop_more) chk(tag, "redirect_pc", redirect_pc, m[1][0]);
      chk(tag, "err_ovf", {31'd0, err_ovf}, {31'd0, mo});
      chk(tag, "err_idx", {31'd0, err_idx}, {31'd0, mi});
   endtask

   task automatic update();
      logic hit, more, last, ovf, bad;
      logic [31:0] pv [3];
      pv[0] = push_cnt; pv[1] = push_start; pv[2] = push_end;
      hit  = pc_vld && m[0][0] != 0 && pc == m[2][0];
      more = hit && m[0][0] > 1;
      last = hit && m[0][0] == 1;
      ovf  = 0;
      for (int c = 0; c < 3; c++) begin
         if (last || (pop_en[c] && !push_en[c] && !(c == 0 && more))) begin
            for (int i = 0; i < 3; i++) m[c][i] = m[c][i+1];
            m[c][3] = 0;
         end else if (c == 0 && more) begin
            m[0][0] = m[0][0] - 1;
         end else if (push_en[c]) begin
            if (m[c][3] != 0) ovf = 1;
            else begin
               for (int i = 3; i > 0; i--) m[c][i] = m[c][i-1];
               m[c][0] = pv[c];
            end
         end else if (c == 0 && l0w_en) begin
            m[0][0] = l0w_val;
         end else if (wr_en && wr_col == c && wr_lvl < 4) begin
            m[c][wr_lvl] = wr_val;
         end
      end
      bad = (wr_en && (wr_col > 2 || wr_lvl > 3)) || (win_rd && win_idx > 11);
      mo = (mo && !err_clr) || ovf;
      mi = (mi && !err_clr) || bad;
   endtask

   task automatic cycle(string tag);
      #1 compare(tag);
      @(posedge clk);
      update();
      @(negedge clk);
      idle();
   endtask

   task automatic push3(logic [31:0] c, logic [31:0] s, logic [31:0] e);
      push_en = 3'b111; push_cnt = c; push_start = s; push_end = e;
   endtask

   initial begin
      rst_n = 0;
      idle();
      for (int c = 0; c < 3; c++) for (int l = 0; l < 4; l++) m[c][l] = 0;
      mo = 0; mi = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      win_idx = 4'd5;
      #1 compare("R1");
      rst_n = 1;
      @(negedge clk);
      idle();

      // R2: three pushes on every column
      push3(5, 32'h100, 32'h1F0); cycle("R2");
      push3(6, 32'h200, 32'h2F0); cycle("R2");
      push3(7, 32'h300, 32'h3F0); cycle("R2");
      for (int i = 0; i < 12; i++) begin win_idx = 4'(i); cycle("R2"); end

      // R3: pop all columns, deepest gets zero
      pop_en = 3'b111; cycle("R3");
      for (int i = 0; i < 12; i++) begin win_idx = 4'(i); cycle("R3"); end

      // R5: columns move independently
      push_en = 3'b001; push_cnt = 9; cycle("R5");
      pop_en = 3'b100; cycle("R5");
      push_en = 3'b010; pop_en = 3'b101; push_start = 32'h440; cycle("R5");
      for (int i = 0; i < 12; i++) begin win_idx = 4'(i); cycle("R5"); end

      // R6: invalid window indices
      for (int i = 12; i < 16; i++) begin win_idx = 4'(i); cycle("R6"); end
      win_rd = 1; win_idx = 4'd13; cycle("R6");
      cycle("R6");
      err_clr = 1; cycle("R12");
      win_rd = 1; win_idx = 4'd11; cycle("R6");
      cycle("R6");

      // R7: level-0 count overwrite
      l0w_en = 1; l0w_val = 32'h55; cycle("R7");
      cycle("R7");

      // R8: indexed writes, valid and malformed
      wr_en = 1; wr_col = 2; wr_lvl = 3; wr_val = 32'hABC; cycle("R8");
      win_idx = 4'd11; cycle("R8");
      wr_en = 1; wr_col = 1; wr_lvl = 2; wr_val = 32'h777; cycle("R8");
      win_idx = 4'd6; cycle("R8");
      wr_en = 1; wr_col = 0; wr_lvl = 4; wr_val = 32'h999; cycle("R8");
      for (int i = 0; i < 12; i++) begin win_idx = 4'(i); cycle("R8"); end
      err_clr = 1; cycle("R12");
      wr_en = 1; wr_col = 3; wr_lvl = 0; wr_val = 32'h999; cycle("R8");
      cycle("R8");
      err_clr = 1; cycle("R12");

      // R4 / R12: fill the count column and push once more
      for (int i = 0; i < 5; i++) begin push_en = 3'b001; push_cnt = 32'(20 + i); cycle("R4"); end
      for (int i = 0; i < 4; i++) begin win_idx = 4'(i); cycle("R4"); end
      repeat (3) cycle("R12");
      push_en = 3'b001; push_cnt = 1; err_clr = 1; cycle("R12");
      cycle("R12");
      err_clr = 1; cycle("R12");
      cycle("R12");
      repeat (4) begin pop_en = 3'b111; cycle("R3"); end

      // R9 / R10: three-iteration loop at 0x140
      push3(3, 32'h100, 32'h140); cycle("R9");
      pc_vld = 1; pc = 32'h13C; cycle("R9");
      pc_vld = 1; pc = 32'h140; cycle("R9");
      pc_vld = 1; pc = 32'h140; cycle("R9");
      pc_vld = 1; pc = 32'h140; cycle("R10");
      win_idx = 4'd0; cycle("R10");
      pc_vld = 1; pc = 32'h0; cycle("R9");

      // R11: competing commands in one cycle
      push3(2, 32'h500, 32'h540); cycle("R11");
      push_en = 3'b001; push_cnt = 4; pop_en = 3'b001; l0w_en = 1; l0w_val = 8;
      wr_en = 1; wr_col = 0; wr_lvl = 0; wr_val = 9; cycle("R11");
      pop_en = 3'b001; l0w_en = 1; l0w_val = 8; cycle("R11");
      l0w_en = 1; l0w_val = 2; wr_en = 1; wr_col = 0; wr_lvl = 0; wr_val = 3; cycle("R11");
      pc_vld = 1; pc = 32'h540; push_en = 3'b001; push_cnt = 6; cycle("R11");
      pc_vld = 1; pc = 32'h540; push_en = 3'b110; push_start = 1; push_end = 2;
      wr_en = 1; wr_col = 2; wr_lvl = 1; wr_val = 5; cycle("R11");
      for (int i = 0; i < 12; i++) begin win_idx = 4'(i); cycle("R11"); end

      // mixed traffic
      for (int n = 0; n < 6000; n++) begin
         for (int c = 0; c < 3; c++) begin
            push_en[c] = ($urandom_range(0, 3) == 0);
            pop_en[c]  = ($urandom_range(0, 4) == 0);
         end
         push_cnt   = $urandom_range(0, 4);
         push_start = $urandom;
         push_end   = ($urandom_range(0, 1) == 0) ? m[2][0] : $urandom;
         l0w_en  = ($urandom_range(0, 15) == 0); l0w_val = $urandom_range(0, 5);
         wr_en   = ($urandom_range(0, 7) == 0);
         wr_col  = 2'($urandom_range(0, 3)); wr_lvl = 3'($urandom_range(0, 5));
         wr_val  = $urandom_range(0, 6);
         win_rd  = ($urandom_range(0, 3) == 0); win_idx = 4'($urandom_range(0, 15));
         pc_vld  = ($urandom_range(0, 3) != 0);
         pc      = ($urandom_range(0, 1) == 0) ? m[2][0] : $urandom;
         err_clr = ($urandom_range(0, 9) == 0);
         cycle("R5");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog got=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule